// File: doc/BRIEF.md
# Saturating Event Counter Unit

This block counts events from a cache controller for performance monitoring. It holds two identical event counters. Each counter has a configuration register that selects one of fifteen single-cycle event strobes and a value register that software can read and write. A shared control register holds one master enable bit, and nothing counts while that bit is clear. A counter that reaches all-ones stays there instead of wrapping to zero.

Software reaches the registers through a plain word-wide write strobe, an address and a combinational read path. The usual use is to clear a value register, choose a source, set the master enable, and read the value later. Each counter has a sticky status bit that records that it has saturated. A per-counter enable can route that status bit to a single interrupt line. Software clears a status bit by writing 1 to it.

Top module: `sat_evt_ctr_unit`

## Requirements
- R1: After reset every register reads zero and `sat_irq` is low.
- R2: While control bit 0 (byte address 0x00) is clear, neither counter value changes except by a software write.
- R3: A configuration register holds a source code in bits [5:2]. Code k (1 to 9) counts pulses on `evt_strobe[k-1]`, adding one for each cycle in which that strobe is high. The counter ignores all other strobes.
- R4: Source code 0 is the disabled code, and a counter holding it never increments.
- R5: Codes 0xA to 0xF count `evt_strobe[k-1]` when `EXTENDED` is 1. When `EXTENDED` is 0 they behave as the disabled code.
- R6: A counter at all-ones stays at all-ones on further events and never wraps.
- R7: The register pairs sit at descending addresses. Counter 1's configuration is at 0x08 and counter 0's is at 0x0C. Counter 1's value is at 0x10 and counter 0's is at 0x14.
- R8: A value-register write lands in the next cycle. A counted event that arrives in the same cycle is dropped.
- R9: The status register at 0x04 holds bit i for counter i. A bit sets in the cycle an increment brings that counter to all-ones and stays set until software writes 1 to it.
- R10: `sat_irq` is high exactly when some counter has its status bit set together with configuration bit 0 (its interrupt enable).
- R11: Only control bit 0 and configuration bits [5:2] and [0] can be written. All other bits of these registers read as zero.
- R12: The two counters count independently, each from its own selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| evt_strobe | input | 15 | Event pulses; bit k-1 belongs to source code k |
| sat_irq | output | 1 | Saturation interrupt |

## Verification
The assertions check on every cycle that a saturated counter holds its value, that a counter moves by at most one step, that a write loads exactly the written value, that nothing counts while the enable is clear, that the disabled code yields no strobe, and that status bits stay set. Only the bench scenarios can show which strobe each code maps to and the descending register layout. The same holds for the non-extended variant treating high codes as disabled and for the interrupt depending on the enable bit.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int NCTR    = 2;
  localparam int NEVT    = 15;
  localparam int SRC_W   = 4;
  localparam int SRC_LSB = 2;
  localparam int IEN_BIT = 0;
  localparam int LAST_BASIC = 9;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_CFG0 = 'h0C;
  localparam int OFF_VAL0 = 'h14;
  localparam int STRIDE   = 4;
endpackage

// File: rtl/sec_src_mux.sv
module sec_src_mux
  import sec_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_code,
  input  logic [NEVT-1:0]  evt,
  output logic             strobe
);
  logic [NEVT:0] padded;
  logic          valid;

  always_comb begin
    padded = {evt, 1'b0};
    valid  = (src_code != '0) &&
             (EXTENDED || (int'(src_code) <= LAST_BASIC));
    strobe = valid ? padded[src_code] : 1'b0;
  end

  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_code == '0) |-> !strobe);
endmodule

// File: rtl/sec_sat_counter.sv
module sec_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] q,
  output logic             hit_max
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  logic [CNT_W-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_en    = load || (inc && (q != MAXV));
    q_d     = load ? load_val : (q + 1'b1);
    hit_max = !load && inc && (q == MAXV - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q == MAXV && !load) |=> (q == MAXV));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (q == $past(q) || q == $past(q) + 1'b1));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));
endmodule

// File: rtl/sec_reg_decode.sv
module sec_reg_decode
  import sec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        ctrl_en,
  input  logic [NCTR-1:0]             sat,
  input  logic [NCTR-1:0][SRC_W-1:0]  cfg_src,
  input  logic [NCTR-1:0]             cfg_ien,
  input  logic [NCTR-1:0][CNT_W-1:0]  vals,
  output logic                        sel_ctrl,
  output logic                        sel_stat,
  output logic [NCTR-1:0]             sel_cfg,
  output logic [NCTR-1:0]             sel_val,
  output logic [CNT_W-1:0]            rdata
);
  genvar gi;
  generate
    for (gi = 0; gi < NCTR; gi++) begin : g_sel
      assign sel_cfg[gi] = (addr == ADDR_W'(OFF_CFG0 - STRIDE * gi));
      assign sel_val[gi] = (addr == ADDR_W'(OFF_VAL0 - STRIDE * gi));
    end
  endgenerate

  assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
  assign sel_stat = (addr == ADDR_W'(OFF_STAT));

  always_comb begin
    rdata = '0;
    if (sel_ctrl) rdata[0] = ctrl_en;
    if (sel_stat) rdata[NCTR-1:0] = sat;
    for (int i = 0; i < NCTR; i++) begin
      if (sel_cfg[i]) begin
        rdata[SRC_LSB +: SRC_W] = cfg_src[i];
        rdata[IEN_BIT]          = cfg_ien[i];
      end
      if (sel_val[i]) rdata = vals[i];
    end
  end
endmodule

// File: rtl/sat_evt_ctr_unit.sv
module sat_evt_ctr_unit
  import sec_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 32,
  parameter bit EXTENDED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NEVT-1:0]   evt_strobe,
  output logic              sat_irq
);
  logic                       ctrl_en_q, ctrl_en_d;
  logic [NCTR-1:0]            sat_q, sat_d;
  logic [NCTR-1:0][SRC_W-1:0] src_q, src_d;
  logic [NCTR-1:0]            ien_q, ien_d;
  logic [NCTR-1:0][CNT_W-1:0] vals;
  logic [NCTR-1:0]            hit_max, strobe, load, inc;
  logic                       sel_ctrl, sel_stat;
  logic [NCTR-1:0]            sel_cfg, sel_val;

  sec_reg_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
    .addr(bus_addr), .ctrl_en(ctrl_en_q), .sat(sat_q), .cfg_src(src_q),
    .cfg_ien(ien_q), .vals(vals), .sel_ctrl(sel_ctrl), .sel_stat(sel_stat),
    .sel_cfg(sel_cfg), .sel_val(sel_val), .rdata(bus_rdata)
  );

  always_comb begin
    ctrl_en_d = (bus_wr && sel_ctrl) ? bus_wdata[0] : ctrl_en_q;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCTR; gi++) begin : g_ctr
      sec_src_mux #(.EXTENDED(EXTENDED)) u_mux (
        .clk(clk), .rst_n(rst_n), .src_code(src_q[gi]),
        .evt(evt_strobe), .strobe(strobe[gi])
      );

      assign load[gi] = bus_wr && sel_val[gi];
      assign inc[gi]  = ctrl_en_q && strobe[gi] && !load[gi];

      sec_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load[gi]), .load_val(bus_wdata),
        .inc(inc[gi]), .q(vals[gi]), .hit_max(hit_max[gi])
      );

      always_comb begin
        src_d[gi] = src_q[gi];
        ien_d[gi] = ien_q[gi];
        if (bus_wr && sel_cfg[gi]) begin
          src_d[gi] = bus_wdata[SRC_LSB +: SRC_W];
          ien_d[gi] = bus_wdata[IEN_BIT];
        end
        sat_d[gi] = (sat_q[gi] && !(bus_wr && sel_stat && bus_wdata[gi]))
                    || hit_max[gi];
      end

      p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en_q && !load[gi]) |=> $stable(vals[gi]));
      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_q[gi] && !(bus_wr && sel_stat && bus_wdata[gi])) |=> sat_q[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= 1'b0;
      sat_q     <= '0;
      src_q     <= '0;
      ien_q     <= '0;
    end else begin
      ctrl_en_q <= ctrl_en_d;
      sat_q     <= sat_d;
      src_q     <= src_d;
      ien_q     <= ien_d;
    end
  end

  assign sat_irq = |(sat_q & ien_q);

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sat_irq |-> (sat_q != '0));
endmodule

// File: tb/tb_sat_evt_ctr_unit.sv
module tb_sat_evt_ctr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, base_rdata;
  logic [14:0] evt_strobe = '0;
  logic        sat_irq, base_irq;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sat_evt_ctr_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe),
    .sat_irq(sat_irq)
  );
  sat_evt_ctr_unit #(.EXTENDED(1'b0)) dut_base (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(base_rdata), .evt_strobe(evt_strobe),
    .sat_irq(base_irq)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_CFG1 = 8'h08,
                         A_CFG0 = 8'h0C, A_VAL1 = 8'h10, A_VAL0 = 8'h14;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [14:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_strobe = m;
      @(negedge clk); evt_strobe = '0;
    end
  endtask

  task automatic cfg(input int ctr, input logic [3:0] src, input logic ien);
    wr(ctr == 0 ? A_CFG0 : A_CFG1, {26'd0, src, 1'b0, ien});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    foreach (A_LIST[i]) begin
      rd(A_LIST[i], d); chk("R1 reset read", d, 32'h0);
    end
    chk("R1 irq", {31'd0, sat_irq}, 32'h0);
  endtask
  localparam logic [7:0] A_LIST [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14};

  task automatic t_gate;
    logic [31:0] d;
    cfg(0, 4'h2, 1'b0);
    pulse(15'h0002, 3);
    rd(A_VAL0, d); chk("R2 disabled no count", d, 32'h0);
  endtask

  task automatic t_sources;
    logic [31:0] d;
    wr(A_CTRL, 32'h1);
    cfg(0, 4'h2, 1'b0); cfg(1, 4'h9, 1'b0);
    pulse(15'h0002, 3);
    pulse(15'h0100, 2);
    pulse(15'h7FFD & ~15'h0100, 2);
    rd(A_VAL0, d); chk("R3 code 2 count", d, 32'd3);
    rd(A_VAL1, d); chk("R12 code 9 count on ctr1", d, 32'd2);
    rd(A_CFG0, d); chk("R7 cfg0 at 0x0C", d, 32'h08);
    rd(A_CFG1, d); chk("R7 cfg1 at 0x08", d, 32'h24);
    pulse(15'h0102, 1);
    rd(A_VAL0, d); chk("R12 ctr0 both", d, 32'd4);
    rd(A_VAL1, d); chk("R12 ctr1 both", d, 32'd3);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(A_VAL0, 32'd0); cfg(0, 4'h0, 1'b0);
    pulse(15'h7FFF, 3);
    rd(A_VAL0, d); chk("R4 code 0 no count", d, 32'd0);
  endtask

  task automatic t_extended;
    logic [31:0] d;
    wr(A_VAL0, 32'd0); cfg(0, 4'hB, 1'b0);
    pulse(15'h0400, 2);
    rd(A_VAL0, d); chk("R5 ext code B counts", d, 32'd2);
    @(negedge clk); bus_addr = A_VAL0; #1 d = base_rdata;
    chk("R5 base variant B disabled", d, 32'd0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    cfg(0, 4'h1, 1'b0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = A_VAL0; bus_wdata = 32'd5;
    evt_strobe = 15'h0001;
    @(negedge clk); bus_wr = 1'b0; evt_strobe = '0;
    rd(A_VAL0, d); chk("R8 write wins over event", d, 32'd5);
    pulse(15'h0001, 1);
    rd(A_VAL0, d); chk("R8 count after load", d, 32'd6);
  endtask

  task automatic t_saturate;
    logic [31:0] d;
    wr(A_STAT, 32'h3);
    cfg(0, 4'h1, 1'b1); cfg(1, 4'h3, 1'b0);
    wr(A_VAL0, 32'hFFFF_FFFE); wr(A_VAL1, 32'hFFFF_FFFE);
    rd(A_STAT, d); chk("R9 load does not set status", d, 32'h0);
    pulse(15'h0004, 1);
    rd(A_STAT, d); chk("R9 status ctr1 set", d, 32'h2);
    chk("R10 no irq when ien clear", {31'd0, sat_irq}, 32'h0);
    pulse(15'h0001, 3);
    rd(A_VAL0, d); chk("R6 saturate", d, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R9 status both", d, 32'h3);
    chk("R10 irq with ien", {31'd0, sat_irq}, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R9 w1c clears bit0 only", d, 32'h2);
    chk("R10 irq drops", {31'd0, sat_irq}, 32'h0);
    pulse(15'h0001, 2);
    rd(A_STAT, d); chk("R9 no reset while held", d, 32'h2);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R11 ctrl reserved", d, 32'h1);
    wr(A_CFG1, 32'hFFFF_FFFF);
    rd(A_CFG1, d); chk("R11 cfg reserved", d, 32'h3D);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); chk("R2 enable cleared", d, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset; t_gate; t_sources; t_disabled; t_extended;
        t_priority; t_saturate; t_reserved;
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule